// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block tracks reservations for load-locked / store-conditional pairs issued by several CPU ports that share one memory. Each port presents one operation per cycle: idle, a locked load, a conditional store, or an ordinary store. The monitor keeps a reservation flag and a granule address for every port. For each conditional store it decides in the same cycle whether the store may commit. It also produces the status word that the CPU writes back into the store's data register.

A granule is 64 bytes wide, which is the address with its low six bits dropped. A committed conditional store cancels the reservations of every port. An ordinary store cancels only the reservations whose granule it hits. When several ports try to commit in the same cycle, a fixed priority picks one of them. The memory itself, and any arbitration beyond that fixed priority, sit outside the block.

Top module: `llsc_monitor`

## Requirements
- R1: A locked load stores its address with the low GRAN_BITS (default 6) bits cleared as the port's granule, and sets the port's reservation flag at the next clock edge.
- R2: A conditional store commits only if its port's reservation flag is set. Otherwise it fails.
- R3: At the clock edge after a committed conditional store, the reservation flags of all ports are cleared.
- R4: A committed conditional store raises `mem_we` for its port in the same cycle and returns the status value 1 on its slice of `sc_status`.
- R5: A failed conditional store keeps `mem_we` low and returns the status value 0.
- R6: The number of ports is set by the parameter NUM_PORTS. Port p uses bits [2p+1:2p] of `req_op` and slice p of `req_addr` and `sc_status`, and the highest port behaves exactly like the others.
- R7: An ordinary store from any port always raises that port's `mem_we`. It clears every reservation whose granule equals the store's granule, and leaves reservations in other granules in place.
- R8: When several reserved ports issue conditional stores in the same cycle, the lowest-numbered one commits and the others fail. A lower-numbered port without a reservation does not block a higher one.
- R9: Synchronous active-high reset clears all reservation flags.
- R10: A new locked load replaces the port's earlier granule address.
- R11: A locked load in the same cycle as a clearing event (a commit or a matching ordinary store) leaves its own port reserved.
- R12: The operation encoding is 00 idle, 01 locked load, 10 conditional store, 11 ordinary store. `sc_done` is high only for a conditional store. For any other operation, `mem_we` is low (except for an ordinary store) and the status slice is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 2*NUM_PORTS | Per-port operation code |
| req_addr | input | NUM_PORTS*ADDR_W | Per-port byte address |
| mem_we | output | NUM_PORTS | Per-port memory write permission this cycle |
| sc_done | output | NUM_PORTS | Per-port conditional store being answered |
| sc_status | output | NUM_PORTS*DATA_W | Per-port status word for write-back (1 = committed) |

## Verification
The hardest situation to reach from the ports is a collision: in one cycle, several reserved ports issue conditional stores while another port issues a locked load, so that commit priority, global clearing and re-reservation all happen together. The stimulus first gives chosen ports their reservations in earlier cycles, then fires the colliding cycle. It reads the surviving reservation state only through later conditional stores. Granule matching is probed with ordinary stores at the last byte inside a granule and at the first byte of the next granule.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE     = 2'b00,
        OP_LOCK_LD  = 2'b01,
        OP_COND_ST  = 2'b10,
        OP_PLAIN_ST = 2'b11
    } mem_op_e;

    typedef struct packed {
        logic lock_ld;
        logic cond_st;
        logic plain_st;
    } op_dec_t;

    function automatic op_dec_t decode_op(input logic [1:0] code);
        op_dec_t d;
        d.lock_ld  = (mem_op_e'(code) == OP_LOCK_LD);
        d.cond_st  = (mem_op_e'(code) == OP_COND_ST);
        d.plain_st = (mem_op_e'(code) == OP_PLAIN_ST);
        return d;
    endfunction

endpackage

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot #(
    parameter int GRAN_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_i,
    input  logic [GRAN_W-1:0] gran_i,
    input  logic              drop_i,
    output logic              flag_o,
    output logic [GRAN_W-1:0] gran_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            gran_o <= '0;
        end else if (set_i) begin
            flag_o <= 1'b1;
            gran_o <= gran_i;
        end else if (drop_i) begin
            flag_o <= 1'b0;
        end
    end

    AST_LL_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        set_i |=> (flag_o && gran_o == $past(gran_i))); // R1

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (drop_i && !set_i) |=> !flag_o); // R7

endmodule

// File: rtl/llsc_sc_arbiter.sv
module llsc_sc_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cand_i,
    output logic [N-1:0] grant_o
);

    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (cand_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
    end

    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R8

    AST_GRANT_NEEDS_RESV: assert property (@(posedge clk) disable iff (rst)
        (grant_o & ~cand_i) == '0); // R2

endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
    import llsc_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 64,
    parameter int GRAN_BITS = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [2*NUM_PORTS-1:0]      req_op,
    input  logic [NUM_PORTS*ADDR_W-1:0] req_addr,
    output logic [NUM_PORTS-1:0]        mem_we,
    output logic [NUM_PORTS-1:0]        sc_done,
    output logic [NUM_PORTS*DATA_W-1:0] sc_status
);

    localparam int GRAN_W = ADDR_W - GRAN_BITS;

    op_dec_t             dec      [NUM_PORTS];
    logic [GRAN_W-1:0]   req_gran [NUM_PORTS];
    logic [GRAN_W-1:0]   resv_gran[NUM_PORTS];
    logic [NUM_PORTS-1:0] resv_flag;
    logic [NUM_PORTS-1:0] ll_vec;
    logic [NUM_PORTS-1:0] cand;
    logic [NUM_PORTS-1:0] grant;
    logic [NUM_PORTS-1:0] snoop_hit;
    logic                 any_commit;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign dec[p]      = decode_op(req_op[2*p +: 2]);
        assign req_gran[p] = req_addr[p*ADDR_W + GRAN_BITS +: GRAN_W];
        assign ll_vec[p]   = dec[p].lock_ld;
        assign cand[p]     = dec[p].cond_st && resv_flag[p];
    end

    llsc_sc_arbiter #(.N(NUM_PORTS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .cand_i  (cand),
        .grant_o (grant)
    );

    assign any_commit = |grant;

    always_comb begin
        snoop_hit = '0;
        for (int s = 0; s < NUM_PORTS; s++) begin
            for (int j = 0; j < NUM_PORTS; j++) begin
                if (dec[j].plain_st && req_gran[j] == resv_gran[s])
                    snoop_hit[s] = 1'b1;
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_slot
        llsc_resv_slot #(.GRAN_W(GRAN_W)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .set_i  (dec[p].lock_ld),
            .gran_i (req_gran[p]),
            .drop_i (any_commit || snoop_hit[p]),
            .flag_o (resv_flag[p]),
            .gran_o (resv_gran[p])
        );

        assign mem_we[p]                       = dec[p].plain_st || grant[p];
        assign sc_done[p]                      = dec[p].cond_st;
        assign sc_status[p*DATA_W +: DATA_W]   = DATA_W'(grant[p]);

        AST_NO_RESV_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
            (dec[p].cond_st && !resv_flag[p]) |->
            (!mem_we[p] && sc_status[p*DATA_W +: DATA_W] == '0)); // R5

        AST_RESV_COMMITS_ALONE: assert property (@(posedge clk) disable iff (rst)
            (dec[p].cond_st && resv_flag[p] && p == 0) |->
            (mem_we[p] && sc_status[p*DATA_W +: DATA_W] == DATA_W'(1))); // R4

        if (p > 0) begin : g_prio
            AST_LOWER_WINS: assert property (@(posedge clk) disable iff (rst)
                (|cand[p-1:0]) |-> !grant[p]); // R8
        end
    end

    AST_COMMIT_CLEARS_ALL: assert property (@(posedge clk) disable iff (rst)
        (any_commit && ll_vec == '0) |=> (resv_flag == '0)); // R3

    AST_LL_SURVIVES: assert property (@(posedge clk) disable iff (rst)
        (any_commit && ll_vec != '0) |=> ((resv_flag & $past(ll_vec)) == $past(ll_vec))); // R11

endmodule

// File: tb/tb_llsc_monitor.sv
module tb_llsc_monitor;

    localparam int CLK_P = 10;
    localparam int NP    = 4;
    localparam int AW    = 32;
    localparam int DW    = 64;
    localparam int GB    = 6;

    localparam logic [1:0] C_IDLE = 2'b00;
    localparam logic [1:0] C_LL   = 2'b01;
    localparam logic [1:0] C_SC   = 2'b10;
    localparam logic [1:0] C_ST   = 2'b11;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [2*NP-1:0]      req_op = '0;
    logic [NP*AW-1:0]     req_addr = '0;
    logic [NP-1:0]        mem_we;
    logic [NP-1:0]        sc_done;
    logic [NP*DW-1:0]     sc_status;

    always #(CLK_P/2) clk = ~clk;

    llsc_monitor #(.NUM_PORTS(NP), .ADDR_W(AW), .DATA_W(DW), .GRAN_BITS(GB)) dut (
        .clk       (clk),
        .rst       (rst),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .mem_we    (mem_we),
        .sc_done   (sc_done),
        .sc_status (sc_status)
    );

    typedef struct {
        int          port;
        logic        done;
        logic        we;
        logic [DW-1:0] status;
        string       tag;
    } exp_t;

    exp_t q[$];
    event drv_ev;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 0;

    logic [1:0]     t_op  [NP];
    logic [AW-1:0]  t_addr[NP];
    logic           m_flag[NP];
    logic [AW-1:0]  m_gran[NP];

    function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
        return a >> GB;
    endfunction

    task automatic clear_req();
        for (int i = 0; i < NP; i++) begin
            t_op[i]   = C_IDLE;
            t_addr[i] = '0;
        end
    endtask

    task automatic put(input int p, input logic [1:0] op, input logic [AW-1:0] a);
        t_op[p]   = op;
        t_addr[p] = a;
    endtask

    task automatic cycle(input string tag);
        int  win;
        logic kill;
        @(negedge clk);
        for (int i = 0; i < NP; i++) begin
            req_op[2*i +: 2]     = t_op[i];
            req_addr[i*AW +: AW] = t_addr[i];
        end
        win = -1;
        for (int i = 0; i < NP; i++)
            if (t_op[i] == C_SC && m_flag[i] && win < 0) win = i;
        for (int i = 0; i < NP; i++) begin
            exp_t e;
            e.port   = i;
            e.done   = (t_op[i] == C_SC);
            e.we     = (t_op[i] == C_ST) || (i == win);
            e.status = (i == win) ? DW'(1) : DW'(0);
            e.tag    = tag;
            q.push_back(e);
        end
        -> drv_ev;
        for (int i = 0; i < NP; i++) begin
            kill = (win >= 0);
            for (int j = 0; j < NP; j++)
                if (t_op[j] == C_ST && gran(t_addr[j]) == m_gran[i]) kill = 1'b1;
            if (t_op[i] == C_LL) begin
                m_flag[i] = 1'b1;
                m_gran[i] = gran(t_addr[i]);
            end else if (kill) begin
                m_flag[i] = 1'b0;
            end
        end
        clear_req();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        req_op   = '0;
        req_addr = '0;
        for (int i = 0; i < NP; i++) begin
            m_flag[i] = 1'b0;
            m_gran[i] = '0;
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        forever begin
            @(drv_ev);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                logic [DW-1:0] got;
                e   = q.pop_front();
                got = sc_status[e.port*DW +: DW];
                n_cmp++;
                if (sc_done[e.port] !== e.done || mem_we[e.port] !== e.we || got !== e.status) begin
                    n_bad++;
                    $display("FAIL %s port %0d: done/we/status got %b/%b/%0h expected %b/%b/%0h",
                             e.tag, e.port, sc_done[e.port], mem_we[e.port], got,
                             e.done, e.we, e.status);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 50000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clear_req();
        do_reset();

        // R9: after reset nobody holds a reservation
        for (int i = 0; i < NP; i++) put(i, C_SC, 32'h100);
        cycle("R9 reset state");

        // R1/R4: lock then commit; R5/R3: second attempt fails
        put(0, C_LL, 32'h1023);
        cycle("R1 lock");
        put(0, C_SC, 32'h1023);
        cycle("R4 commit");
        put(0, C_SC, 32'h1023);
        cycle("R5 retry fails");

        // R3: a commit on port 1 kills ports 0 and 2
        put(0, C_LL, 32'h500); put(1, C_LL, 32'h600); put(2, C_LL, 32'h700);
        cycle("R1 lock three");
        put(1, C_SC, 32'h600);
        cycle("R4 port1 commit");
        put(0, C_SC, 32'h500); put(2, C_SC, 32'h700);
        cycle("R3 others cleared");

        // R7/R1: ordinary store at last byte of the granule clears
        put(1, C_LL, 32'h2000);
        cycle("R1 lock");
        put(3, C_ST, 32'h203F);
        cycle("R7 store same granule");
        put(1, C_SC, 32'h2000);
        cycle("R7 cleared by store");
        // next granule leaves it
        put(1, C_LL, 32'h2000);
        cycle("R1 relock");
        put(3, C_ST, 32'h2040);
        cycle("R7 store next granule");
        put(1, C_SC, 32'h2000);
        cycle("R7 survives other granule");

        // R8: simultaneous commits, lowest reserved wins
        put(2, C_LL, 32'h3000); put(3, C_LL, 32'h3100);
        cycle("R1 lock two");
        put(0, C_SC, 32'h0); put(2, C_SC, 32'h3000); put(3, C_SC, 32'h3100);
        cycle("R8 collision");
        put(3, C_SC, 32'h3100);
        cycle("R3 loser cleared");

        // R10: relock moves the granule
        put(0, C_LL, 32'h4000);
        cycle("R10 first lock");
        put(0, C_LL, 32'h5000);
        cycle("R10 second lock");
        put(2, C_ST, 32'h4000);
        cycle("R10 store old granule");
        put(0, C_SC, 32'h5000);
        cycle("R10 old granule ignored");
        put(0, C_LL, 32'h4000);
        cycle("R10 lock");
        put(0, C_LL, 32'h5000);
        cycle("R10 relock");
        put(1, C_ST, 32'h5008);
        cycle("R10 store new granule");
        put(0, C_SC, 32'h5000);
        cycle("R10 new granule cleared");

        // R11: lock alongside a commit survives
        put(0, C_LL, 32'h6000);
        cycle("R1 lock");
        put(0, C_SC, 32'h6000); put(1, C_LL, 32'h7000); put(2, C_ST, 32'h7000);
        cycle("R11 lock with commit and store");
        put(1, C_SC, 32'h7000);
        cycle("R11 lock survived");

        // R12: idle keeps reservation and gives quiet outputs
        put(3, C_LL, 32'h8000);
        cycle("R12 lock");
        cycle("R12 idle");
        cycle("R12 idle");
        put(3, C_SC, 32'h8000);
        cycle("R6 highest port commit");

        // R9: reset mid-run drops held reservations
        for (int i = 0; i < NP; i++) put(i, C_LL, 32'h9000 + i * 32'h100);
        cycle("R1 lock all");
        do_reset();
        for (int i = 0; i < NP; i++) put(i, C_SC, 32'h9000);
        cycle("R9 reset clears");

        repeat (2) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule